// File: doc/BRIEF.md
# Atomic Wide Timer Capture Unit

A free-running 32-bit down-counter whose full value can be frozen into a small capture FIFO in a single clock edge. The bus that reads the block is 16 bits wide. Reading the live count as two halves in sequence can return a mixed value if a borrow ripples between the two reads. The capture path avoids this. Both halves of a captured word come from the same edge, so the word stays coherent however slowly the host or a DMA engine drains it.

Two events take a capture. One is a rising edge on an asynchronous input, which first passes through a two-flop synchronizer. The other is a read access to the live low-half register, which snapshots the whole count as a side effect; the host simply ignores the data that access returns. Captures queue in a four-entry FIFO. Reading the high half of the head entry pops it. A request line stays high while anything is queued, so a DMA channel can be paced by it. A capture that finds the FIFO full is dropped and recorded in a sticky overflow flag.

Top module: `wide_capture_timer`

## Requirements
- R1: Reset loads the counter with all ones. After reset it decreases by one on every clock edge and wraps from zero to all ones.
- R2: The live count appears combinationally on `bus_rdata`. Address 0 gives bits 15:0 and address 1 gives bits 31:16.
- R3: A clock edge with `bus_rd` high and `bus_addr` = 0 writes into the FIFO the full 32-bit count present during that cycle.
- R4: Suppose `cap_in` is sampled high at clock edge E and was sampled low at the edge before E. Then edge E+2 writes into the FIFO the count present in the cycle just before E+2. A pulse held high for any number of cycles gives exactly one capture.
- R5: If an edge capture and a register-triggered capture fall on the same clock edge, exactly one entry is written.
- R6: Entries leave the FIFO oldest first. Address 2 returns the low half of the head entry without popping it. A clock edge with `bus_rd` high and `bus_addr` = 3 pops the entry whose high half is being returned. A pop request on an empty FIFO changes nothing.
- R7: Address 4 reads the status word: bit 0 = empty, bit 1 = full, bit 2 = overflow, bits 6:4 = number of stored entries, all other bits zero.
- R8: A capture arriving while the FIFO holds four entries, with no pop on the same edge, is dropped. It also sets the overflow flag. The flag holds until a write to address 4 with bit 2 set. A write with bit 2 clear leaves it unchanged.
- R9: `cap_req` is high exactly while the FIFO holds at least one entry.
- R10: After reset the FIFO is empty, the overflow flag is clear and `cap_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | Asynchronous capture input, rising edge triggers a capture |
| bus_rd | input | 1 | Read strobe, qualifies read side effects |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| cap_req | output | 1 | Capture-ready request to a DMA engine |

## Verification
A wrong FIFO pointer or fill count shows up quickly at the ports. The status word, `cap_req` or the drained words disagree with the bench's queue of expected counts within the cycle in which the next entry is read. A missed or doubled edge capture appears as a wrong fill level two cycles after the synchronizer sees the edge. A wrong capture instant or a torn word shows as a drained value that differs from the counter's value at the expected edge. A counter that skips or stalls is visible on the very next live read.

// File: rtl/tct_pkg.sv
package tct_pkg;
   localparam int REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_CNT_LO = 3'd0,
      REG_CNT_HI = 3'd1,
      REG_CAP_LO = 3'd2,
      REG_CAP_HI = 3'd3,
      REG_STAT   = 3'd4
   } tct_reg_e;

   localparam int STAT_EMPTY_BIT = 0;
   localparam int STAT_FULL_BIT  = 1;
   localparam int STAT_OVF_BIT   = 2;
   localparam int STAT_LVL_LSB   = 4;
endpackage

// File: rtl/tct_edge_sync.sv
module tct_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
   logic [STAGES:0] sh;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tct_edge_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i <= STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh[0] <= 1'b0;
               else        sh[0] <= async_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= sh[i-1];
         end
      end
   endgenerate

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tct_down_counter.sv
module tct_down_counter #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] count
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("tct_down_counter: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) count <= '1;
      else        count <= count - 1'b1;
endmodule

// File: rtl/tct_capture_fifo.sv
module tct_capture_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [LW-1:0]    level,
   output logic             empty,
   output logic             full,
   output logic             dropped
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("tct_capture_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0]      wr_ptr, rd_ptr;
   logic             do_pop, do_push;

   assign empty   = (wr_ptr == rd_ptr);
   assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign dropped = push && !do_push;
   assign dout    = mem[rd_ptr[AW-1:0]];
   assign level   = LW'(wr_ptr - rd_ptr);

   always_ff @(posedge clk)
      if (do_push) mem[wr_ptr[AW-1:0]] <= din;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      end
endmodule

// File: rtl/wide_capture_timer.sv
module wide_capture_timer
   import tct_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int HALF_W      = 16,
   parameter int FIFO_DEPTH  = 4,
   parameter int SYNC_STAGES = 2,
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap_in,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [HALF_W-1:0]     bus_wdata,
   output logic [HALF_W-1:0]     bus_rdata,
   output logic                  cap_req
);
   generate
      if (CNT_W != 2 * HALF_W) begin : g_bad_split
         $error("wide_capture_timer: CNT_W must be twice HALF_W");
      end
      if (HALF_W < STAT_LVL_LSB + LVL_W) begin : g_bad_stat
         $error("wide_capture_timer: status word does not fit in HALF_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] head;
   logic [LVL_W-1:0] fifo_lvl;
   logic             edge_rise, sw_cap, cap_evt, pop_req;
   logic             fifo_empty, fifo_full, fifo_drop;
   logic             ovf_q, ovf_clr;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata;

   tct_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_in(cap_in), .rise(edge_rise)
   );

   tct_down_counter #(.WIDTH(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .count(cnt_q)
   );

   assign sw_cap  = bus_rd && (bus_addr == REG_CNT_LO);
   assign pop_req = bus_rd && (bus_addr == REG_CAP_HI);
   assign cap_evt = edge_rise || sw_cap;

   tct_capture_fifo #(.WIDTH(CNT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(cap_evt), .din(cnt_q),
      .pop(pop_req), .dout(head),
      .level(fifo_lvl), .empty(fifo_empty), .full(fifo_full),
      .dropped(fifo_drop)
   );

   assign ovf_clr = bus_wr && (bus_addr == REG_STAT) && bus_wdata[STAT_OVF_BIT];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         ovf_q <= 1'b0;
      else if (fifo_drop) ovf_q <= 1'b1;
      else if (ovf_clr)   ovf_q <= 1'b0;

   assign cap_req = !fifo_empty;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_CNT_LO: bus_rdata = cnt_q[HALF_W-1:0];
         REG_CNT_HI: bus_rdata = cnt_q[CNT_W-1:HALF_W];
         REG_CAP_LO: bus_rdata = head[HALF_W-1:0];
         REG_CAP_HI: bus_rdata = head[CNT_W-1:HALF_W];
         REG_STAT: begin
            bus_rdata[STAT_EMPTY_BIT]              = fifo_empty;
            bus_rdata[STAT_FULL_BIT]               = fifo_full;
            bus_rdata[STAT_OVF_BIT]                = ovf_q;
            bus_rdata[STAT_LVL_LSB +: LVL_W]       = fifo_lvl;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
   parameter int CNT_W = 32,
   parameter int DEPTH = 4,
   parameter int LW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic [LW-1:0]    lvl,
   input logic             cap_req,
   input logic             ovf,
   input logic             cap_evt,
   input logic             bus_rd,
   input logic [2:0]       bus_addr
);
   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt == $past(cnt) - 1'b1);

   // R9
   req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_req == (lvl != '0));

   // R5
   one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> int'(lvl) <= int'($past(lvl)) + 1);

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(lvl) <= DEPTH);

   // R8
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> (int'($past(lvl)) == DEPTH) && $past(cap_evt));

   // R6
   pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 3'd3 && lvl != '0 && !cap_evt)
         |=> int'(lvl) == int'($past(lvl)) - 1);
endmodule

bind wide_capture_timer tct_checker #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH), .LW(LVL_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .lvl(fifo_lvl), .cap_req(cap_req),
   .ovf(ovf_q), .cap_evt(cap_evt), .bus_rd(bus_rd), .bus_addr(bus_addr)
);

// File: tb/test_wide_capture_timer.sv
module test_wide_capture_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_in = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        cap_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wide_capture_timer i_wide_capture_timer (
      .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_req(cap_req)
   );

   // counter model from R1
   logic [31:0] exp_cnt;
   always @(posedge clk or negedge rst_n)
      if (!rst_n) exp_cnt <= '1;
      else        exp_cnt <= exp_cnt - 1;

   // expected capture queue
   logic [31:0] q_mem [0:63];
   int q_wr = 0;
   int q_rd = 0;

   // stimulus table: upper nibble = register captures, lower nibble = edge captures
   localparam logic [7:0] VEC [0:5] = '{8'h10, 8'h01, 8'h21, 8'h13, 8'h40, 8'h04};

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] stat_word(int lvl, bit ovf);
      logic [15:0] s;
      s = '0;
      s[0] = (lvl == 0);
      s[1] = (lvl == 4);
      s[2] = ovf;
      s[6:4] = 3'(lvl);
      return s;
   endfunction

   task automatic read_stat(output logic [15:0] s);
      bus_rd = 1'b0;
      bus_addr = 3'd4;
      #1 s = bus_rdata;
   endtask

   task automatic sw_cap(bit keep);
      bus_rd = 1'b1;
      bus_addr = 3'd0;
      #1;
      chk("R2 live low half", {16'h0, bus_rdata}, {16'h0, exp_cnt[15:0]});
      if (keep) begin q_mem[q_wr % 64] = exp_cnt; q_wr++; end
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic edge_cap();
      cap_in = 1'b1;
      q_mem[q_wr % 64] = exp_cnt - 32'd2;
      q_wr++;
      repeat (3) @(negedge clk);
      cap_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic drain(string req);
      logic [15:0] lo, hi;
      bus_rd = 1'b1;
      bus_addr = 3'd2;
      #1 lo = bus_rdata;
      @(negedge clk);
      bus_addr = 3'd3;
      #1 hi = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req, {hi, lo}, q_mem[q_rd % 64]);
      q_rd++;
   endtask

   task automatic write_stat(logic [15:0] d);
      bus_wr = 1'b1;
      bus_addr = 3'd4;
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      bus_wdata = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] s;
      logic [31:0] a, b, ref_v;
      repeat (3) @(negedge clk);
      // reset state
      read_stat(s);
      chk("R10 status in reset", {16'h0, s}, 32'h0001);
      chk("R10 cap_req in reset", {31'h0, cap_req}, 32'h0);
      bus_addr = 3'd1;
      #1 chk("R1 reset count high", {16'h0, bus_rdata}, 32'h0000ffff);
      rst_n = 1'b1;
      @(negedge clk);
      bus_addr = 3'd1;
      #1 chk("R2 live high half", {16'h0, bus_rdata}, {16'h0, exp_cnt[31:16]});
      bus_addr = 3'd0;
      #1 a = {16'h0, bus_rdata};
      chk("R1 first decrement", a, 32'h0000fffe);
      repeat (5) @(negedge clk);
      #1 b = {16'h0, bus_rdata};
      chk("R1 five decrements", a - b, 32'd5);

      // table walk
      for (int v = 0; v < 6; v++) begin
         int nsw, ned, tot;
         nsw = int'(VEC[v][7:4]);
         ned = int'(VEC[v][3:0]);
         tot = nsw + ned;
         for (int i = 0; i < nsw; i++) sw_cap(1'b1);
         for (int i = 0; i < ned; i++) edge_cap();
         read_stat(s);
         chk("R7 status after captures", {16'h0, s}, {16'h0, stat_word(tot, 1'b0)});
         chk("R9 cap_req with entries", {31'h0, cap_req}, 32'h1);
         for (int i = 0; i < tot; i++) drain("R3 R4 R6 drained value");
         read_stat(s);
         chk("R6 empty after drain", {16'h0, s}, 32'h0001);
         chk("R9 cap_req when empty", {31'h0, cap_req}, 32'h0);
      end

      // pop on empty ignored
      bus_rd = 1'b1;
      bus_addr = 3'd3;
      @(negedge clk);
      bus_rd = 1'b0;
      read_stat(s);
      chk("R6 pop on empty ignored", {16'h0, s}, 32'h0001);

      // low-half head read does not pop
      sw_cap(1'b1);
      bus_rd = 1'b1;
      bus_addr = 3'd2;
      repeat (3) @(negedge clk);
      bus_rd = 1'b0;
      read_stat(s);
      chk("R6 low read keeps entry", {16'h0, s}, {16'h0, stat_word(1, 1'b0)});
      drain("R6 value after low reads");

      // overflow
      for (int i = 0; i < 5; i++) sw_cap(i < 4);
      read_stat(s);
      chk("R8 full with overflow", {16'h0, s}, 32'h0046);
      for (int i = 0; i < 4; i++) drain("R8 oldest entries kept");
      read_stat(s);
      chk("R8 overflow sticky", {16'h0, s}, 32'h0005);
      write_stat(16'hfffb);
      read_stat(s);
      chk("R8 write without bit 2", {16'h0, s}, 32'h0005);
      write_stat(16'h0004);
      read_stat(s);
      chk("R8 overflow cleared", {16'h0, s}, 32'h0001);

      // coincident edge and register capture, long pulse
      cap_in = 1'b1;
      ref_v = exp_cnt - 32'd2;
      @(negedge clk);
      @(negedge clk);
      bus_rd = 1'b1;
      bus_addr = 3'd0;
      #1 chk("R5 capture instant alignment", exp_cnt, ref_v);
      q_mem[q_wr % 64] = exp_cnt;
      q_wr++;
      @(negedge clk);
      bus_rd = 1'b0;
      repeat (10) @(negedge clk);
      cap_in = 1'b0;
      repeat (3) @(negedge clk);
      read_stat(s);
      chk("R5 R4 single entry", {16'h0, s}, {16'h0, stat_word(1, 1'b0)});
      drain("R5 coincident value");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule